// File: doc/BRIEF.md
# Critical-Word-First Line Refill Sequencer

This block runs the background refill of one cache line after a store has missed and allocated the line. The controller hands it the longword index of the miss and a per-byte mask of the bytes that the store has already placed in the line. The sequencer then accepts fill longwords from memory over a valid/ready handshake. It turns each one into a line write with a longword index and a byte-enable mask.

Beats are taken in critical-word-first order. The first beat goes to the longword that holds the miss address. Later beats step upward and wrap back to longword 0 of the line. Each beat's byte enables are the inverse of the stored mask for that longword, so bytes the store wrote are never overwritten by older memory data. A longword the store covered completely still takes one beat, with all enables low. The processor is not stalled while this runs.

Once the final beat has been absorbed, a one-cycle completion pulse tells the controller to record the tag and mark the line valid and used. A new start request made while a refill is in progress is refused. The busy output shows whether a request would be accepted.

Top module: `refill_seq`

## Requirements
- R1: A start request (`start_valid` high) is accepted when `busy` is low. `busy` then reads high from the next cycle until the cycle in which `done` is raised.
- R2: A start request made while `busy` is high is ignored. The running refill keeps its longword order and byte masks, and no second refill follows it.
- R3: `fill_ready` equals `busy`. While `busy` is low, `line_we` stays low whatever `fill_valid` does.
- R4: The first beat of a refill writes longword index `start_word`. This index is miss-address bits [4:2] for the default 32-byte line of 4-byte longwords.
- R5: Each later beat writes longword index (previous index + 1) modulo the number of longwords in the line, so the order wraps from the top longword to longword 0.
- R6: On a beat, bit b of `line_bmask` is the inverse of bit (4*i + b) of the captured `start_mask`, where i is the beat's longword index. A fully written longword gives a beat with `line_bmask` = 0 and `line_we` still high.
- R7: A refill consists of exactly eight beats. `done` is high for exactly one cycle, the cycle after the eighth beat's handshake, and `busy` is low in that same cycle.
- R8: A beat happens in a cycle where `busy` and `fill_valid` are both high. In that cycle `line_we` is high and `line_wdata` equals `fill_data`. A cycle with `fill_valid` low writes nothing and does not advance the order.
- R9: While reset is asserted and after it is released, `busy`, `fill_ready`, `line_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to begin a refill |
| start_word | input | IDX_W (3) | Longword index of the miss inside the line |
| start_mask | input | LINE_BYTES (32) | Bytes already written by the store, bit 4*i+b = byte b of longword i |
| busy | output | 1 | Refill in progress; start requests are refused |
| fill_valid | input | 1 | Memory offers a fill longword |
| fill_data | input | 8*WORD_BYTES (32) | Fill longword |
| fill_ready | output | 1 | Sequencer absorbs a fill longword this cycle |
| line_we | output | 1 | Line write strobe, one per beat |
| line_widx | output | IDX_W (3) | Longword index written by this beat |
| line_bmask | output | WORD_BYTES (4) | Byte enables of this beat |
| line_wdata | output | 8*WORD_BYTES (32) | Data written by this beat |
| done | output | 1 | One-cycle pulse: line complete, record tag |

## Verification
The bench starts refills at index 0, at a middle index and at index 7. A design that did not wrap would write past the line or skip the longwords below the miss. It stores masks that cover some longwords fully and others partly. A swapped or non-inverted mask would overwrite store data or drop fill bytes. Gaps in `fill_valid` show whether a stall cycle wrongly advances the order. Start requests held high during a refill, and a new start in the very cycle of `done`, expose a sequencer that restarts in mid-line, loses the completion pulse, or refuses a legal back-to-back request.

// File: rtl/refill_pkg.sv
package refill_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } fill_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_valid,
   input  logic beat,
   input  logic last_beat,
   output logic busy,
   output logic accept,
   output logic done
);
   import refill_pkg::*;

   fill_state_e state_q;
   logic        done_q;

   assign busy   = (state_q == ST_FILL);
   assign accept = start_valid && (state_q == ST_IDLE);
   assign done   = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= beat && last_beat;
         unique case (state_q)
            ST_IDLE: if (accept)            state_q <= ST_FILL;
            ST_FILL: if (beat && last_beat) state_q <= ST_IDLE;
            default:                        state_q <= ST_IDLE;
         endcase
      end
   end

   // a new request while idle always leads to a busy cycle
   assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_valid && !busy) |=> busy);

   // completion is a single-cycle pulse
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // last beat ends the refill and raises completion
   assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && last_beat) |=> (done && !busy));

endmodule

// File: rtl/refill_order.sv
module refill_order #(
   parameter int NUM_WORDS = 8,
   parameter int IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [IDX_W-1:0] start_idx,
   input  logic             beat,
   output logic [IDX_W-1:0] idx,
   output logic             last_beat
);
   localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(NUM_WORDS - 1);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] cnt_q;

   assign idx       = idx_q;
   assign last_beat = (cnt_q == LAST_CNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         cnt_q <= '0;
      end else if (accept) begin
         idx_q <= start_idx;
         cnt_q <= '0;
      end else if (beat) begin
         idx_q <= idx_q + 1'b1;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // order steps by one longword and wraps inside the line
   assert_wrap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !last_beat && !accept) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

   // the first beat starts at the miss longword
   assert_first_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (idx_q == $past(start_idx)));

endmodule

// File: rtl/refill_mask.sv
module refill_mask #(
   parameter int NUM_WORDS  = 8,
   parameter int WORD_BYTES = 4,
   parameter int IDX_W      = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            accept,
   input  logic [NUM_WORDS*WORD_BYTES-1:0] wmask,
   input  logic [IDX_W-1:0]                idx,
   output logic [WORD_BYTES-1:0]           bmask
);
   localparam int LINE_BYTES = NUM_WORDS * WORD_BYTES;

   logic [LINE_BYTES-1:0] mask_q;
   logic [WORD_BYTES-1:0] slice [NUM_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n)      mask_q <= '0;
      else if (accept) mask_q <= wmask;
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_slice
      assign slice[w] = mask_q[w*WORD_BYTES +: WORD_BYTES];
   end

   assign bmask = ~slice[idx];

   // captured store mask is held for the whole refill
   assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(mask_q));

endmodule

// File: rtl/refill_seq.sv
module refill_seq #(
   parameter  int LINE_BYTES = 32,
   parameter  int WORD_BYTES = 4,
   localparam int NUM_WORDS  = LINE_BYTES / WORD_BYTES,
   localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
   localparam int WORD_W     = 8 * WORD_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_valid,
   input  logic [IDX_W-1:0]      start_word,
   input  logic [LINE_BYTES-1:0] start_mask,
   output logic                  busy,
   input  logic                  fill_valid,
   input  logic [WORD_W-1:0]     fill_data,
   output logic                  fill_ready,
   output logic                  line_we,
   output logic [IDX_W-1:0]      line_widx,
   output logic [WORD_BYTES-1:0] line_bmask,
   output logic [WORD_W-1:0]     line_wdata,
   output logic                  done
);
   if (WORD_BYTES < 1 || (LINE_BYTES % WORD_BYTES) != 0) begin : g_bad_word
      $error("refill_seq: line size must be a multiple of the word size");
   end
   if (!refill_pkg::is_pow2(NUM_WORDS) || NUM_WORDS < 2) begin : g_bad_line
      $error("refill_seq: longword count must be a power of two of at least 2");
   end

   logic             accept;
   logic             beat;
   logic             last_beat;
   logic [IDX_W-1:0] idx;

   assign beat = busy && fill_valid;

   refill_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_valid(start_valid),
      .beat       (beat),
      .last_beat  (last_beat),
      .busy       (busy),
      .accept     (accept),
      .done       (done)
   );

   refill_order #(
      .NUM_WORDS(NUM_WORDS),
      .IDX_W    (IDX_W)
   ) u_order (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .start_idx(start_word),
      .beat     (beat),
      .idx      (idx),
      .last_beat(last_beat)
   );

   refill_mask #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_BYTES(WORD_BYTES),
      .IDX_W     (IDX_W)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .accept(accept),
      .wmask (start_mask),
      .idx   (idx),
      .bmask (line_bmask)
   );

   assign fill_ready = busy;
   assign line_we    = beat;
   assign line_widx  = idx;
   assign line_wdata = fill_data;

   // nothing is written or absorbed while idle
   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!fill_ready && !line_we));

   // a refused start with no beat leaves the order untouched
   assert_refuse_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_valid && !fill_valid) |=> (busy && $stable(line_widx)));

   // completion never coincides with a write
   assert_done_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !line_we);

endmodule

// File: tb/refill_seq_bench.sv
`timescale 1ns/1ps
module refill_seq_bench;
   localparam int LB = 32;
   localparam int WB = 4;
   localparam int NW = LB / WB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_valid = 1'b0;
   logic [2:0]    start_word = '0;
   logic [LB-1:0] start_mask = '0;
   logic          fill_valid = 1'b0;
   logic [31:0]   fill_data = '0;
   logic          busy, fill_ready, line_we, done;
   logic [2:0]    line_widx;
   logic [3:0]    line_bmask;
   logic [31:0]   line_wdata;

   always #2.5 clk = ~clk;

   refill_seq #(.LINE_BYTES(LB), .WORD_BYTES(WB)) u_refill_seq (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
      .start_word(start_word), .start_mask(start_mask), .busy(busy),
      .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready),
      .line_we(line_we), .line_widx(line_widx), .line_bmask(line_bmask),
      .line_wdata(line_wdata), .done(done)
   );

   int checks = 0;
   int fails  = 0;
   bit checking = 1'b0;
   bit finished = 1'b0;

   // behavioural reference state
   bit          m_busy = 0;
   bit          m_done = 0;
   int          m_cnt  = 0;
   int          m_idx  = 0;
   bit [LB-1:0] m_mask = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint got, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0; m_idx = 0; m_mask = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            if (fill_valid) begin
               if (m_cnt == NW - 1) begin
                  m_busy = 0;
                  m_done = 1;
               end
               m_cnt++;
               m_idx = (m_idx + 1) % NW;
            end
         end else if (start_valid) begin
            m_busy = 1;
            m_cnt  = 0;
            m_idx  = int'(start_word);
            m_mask = start_mask;
         end
      end
   end

   always @(negedge clk) begin
      #1;
      if (checking && !finished) begin
         bit       exp_we;
         bit [3:0] exp_bm;
         exp_we = m_busy && fill_valid;
         chk(busy == m_busy, "R1", "busy", busy, m_busy);
         chk(fill_ready == m_busy, "R3", "fill_ready", fill_ready, m_busy);
         chk(line_we == exp_we, "R8", "line_we", line_we, exp_we);
         chk(done == m_done, "R7", "done", done, m_done);
         if (exp_we) begin
            exp_bm = ~m_mask[m_idx*WB +: WB];
            if (m_cnt == 0) chk(int'(line_widx) == m_idx, "R4", "first idx", line_widx, m_idx);
            else            chk(int'(line_widx) == m_idx, "R5", "wrap idx", line_widx, m_idx);
            chk(line_bmask == exp_bm, "R6", "bmask", line_bmask, exp_bm);
            chk(line_wdata == fill_data, "R8", "wdata", line_wdata, fill_data);
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // one refill; gap is percent of stall cycles, disturb raises refused starts
   task automatic refill(input bit [2:0] idx, input bit [LB-1:0] mask,
                         input int gap, input bit disturb, input bit b2b);
      if (!b2b) @(negedge clk);
      start_valid = 1'b1; start_word = idx; start_mask = mask;
      @(negedge clk);
      start_valid = disturb; start_word = ~idx; start_mask = ~mask;
      while (m_busy) begin
         fill_valid = (($urandom % 100) >= gap);
         fill_data  = $urandom;
         if (disturb) begin
            start_valid = 1'($urandom % 2);
            start_word  = 3'($urandom);
            start_mask  = {$urandom};
         end
         @(negedge clk);
      end
      fill_valid = 1'b0;
      start_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state held during reset
      chk(!busy && !fill_ready && !line_we && !done, "R9", "reset outputs",
          {busy, fill_ready, line_we, done}, 0);
      fill_valid = 1'b1;
      @(negedge clk);
      chk(!line_we, "R9", "write during reset", line_we, 0);
      fill_valid = 1'b0;
      rst_n = 1'b1;
      checking = 1'b1;
      @(negedge clk);
      // R3: idle offers are ignored
      fill_valid = 1'b1;
      repeat (2) @(negedge clk);
      fill_valid = 1'b0;
      refill(3'd0, '0, 0, 0, 0);                    // R4 R5 start at 0, no stalls
      refill(3'd5, 32'h00F0_0F06, 40, 0, 0);        // R6 partial and full words, stalls
      refill(3'd7, 32'hF000_000F, 30, 1, 0);        // R2 R5 wrap from 7, refused starts
      refill(3'd2, 32'hFFFF_FFFF, 0, 0, 1);         // R6 R7 fully written line, back to back
      refill(3'd6, 32'h1234_5678, 50, 1, 1);        // R2 back to back with disturbance
      for (int k = 0; k < 30; k++)
         refill(3'($urandom), {$urandom}, int'($urandom % 60), 1'($urandom % 2), 1'($urandom % 2));
      repeat (3) @(negedge clk);
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
      end
   end
endmodule